// File: doc/BRIEF.md
# Receive Address Filter with Wake-on-LAN

This block makes the keep-or-drop decision for every received Ethernet frame. When the receive path signals that a frame has ended, the block looks at the frame's 48-bit destination address and the station's own address. It also takes per-frame hit flags from the unicast and multicast hash filters, from four pattern-match units and from a magic-packet detector. Hashing, pattern matching and magic-packet detection happen upstream, and their results arrive here as plain flags.

A control word selects the acceptance rules:

- six acceptance classes, whose results are ORed;
- per-unit enables for the pattern-match units;
- an AND/OR mode that joins the class result with the pattern result;
- two wake sources.

The decision is a registered one-cycle pulse that carries an accept bit. A wake event sets sticky cause bits, and the wake interrupt stays high while any cause is set. Software removes causes by writing a clear mask.

The frame-end strobe is a valid-only event. The block takes one frame per cycle and never applies back-pressure. The decision pulse is valid-only as well and cannot be stalled, so the consumer must capture it in the cycle it appears.

Top module: `rx_addr_filter_wol`

## Requirements
- R1: A destination of all ones is broadcast. A destination whose bit 40 (the least significant bit of the first octet sent) is 1 and that is not broadcast is multicast. Any destination with bit 40 equal to 0 is unicast.
- R2: The class result is the OR of the enabled classes:
  - ctrl[0]: every unicast frame;
  - ctrl[1]: every broadcast frame;
  - ctrl[2]: every multicast frame;
  - ctrl[3]: a unicast frame whose unicast hash flag is set;
  - ctrl[4]: a multicast frame whose multicast hash flag is set;
  - ctrl[5]: a frame whose destination equals the station address.
- R3: The pattern result is the OR of pat_hit_i[k] & ctrl[7+k] for k = 0..3, so unit 0 is enabled by ctrl[7]. With no unit enabled, the pattern result is 0.
- R4: With ctrl[6] = 1, accept = class AND pattern. With ctrl[6] = 0, accept = class OR pattern.
- R5: One cycle after a cycle with frame_end_i high, decision_valid_o is high for one cycle and decision_accept_o carries the decision. In every other cycle both outputs are 0.
- R6: On a frame end with ctrl[12] = 1, the wake status bits are set as follows:
  - bit 0 is set when an enabled perfect match occurs (ctrl[5] and the destination equals the station address);
  - bit 1 is set when the pattern result is 1;
  - bit 2 is set when any of the following occurs: an enabled perfect match, an enabled hash hit (the ctrl[3] or ctrl[4] class is met), or a pattern result of 1.
  With ctrl[12] = 0, these bits are unchanged.
- R7: On a frame end with ctrl[11] = 1 and magic_hit_i = 1, wake status bit 3 is set. With ctrl[11] = 0, bit 3 is unchanged.
- R8: Wake status bits stay set. They change in the cycle after the frame end or the clear. A cycle with clr_we_i = 1 clears the bits that are set in clr_mask_i.
- R9: If a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R10: wake_irq_o is 1 exactly when any wake status bit is 1.
- R11: After reset, decision_valid_o, decision_accept_o, wake_status_o and wake_irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end_i | input | 1 | One-cycle strobe: the frame's inputs are valid |
| dest_addr_i | input | 48 | Destination address of the frame |
| station_addr_i | input | 48 | Station address |
| uc_hash_hit_i | input | 1 | Unicast hash filter hit |
| mc_hash_hit_i | input | 1 | Multicast hash filter hit |
| pat_hit_i | input | 4 | Pattern-match unit hits, bit k is unit k |
| magic_hit_i | input | 1 | Magic packet detected |
| ctrl_i | input | 13 | Control word (layout in R2 to R7) |
| clr_we_i | input | 1 | Clear-register write strobe |
| clr_mask_i | input | 4 | Status bits to clear |
| decision_valid_o | output | 1 | Decision pulse |
| decision_accept_o | output | 1 | Frame accepted (valid with the pulse) |
| wake_status_o | output | 4 | Sticky wake causes |
| wake_irq_o | output | 1 | Wake interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a new wake event for the same cause bit. The bench reaches it by driving the frame-end strobe with a magic hit, together with a clear mask that covers that bit, on a single edge. It then checks that the bit survives. A second hard-to-reach case is the AND mode with every pattern unit disabled, which must reject even frames that the classes would accept. Frames of all three address kinds are sent under each class enable, and a behavioural model compares every output on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W   = 48;
  localparam int NUM_PAT  = 4;
  localparam int NUM_CLS  = 6;
  localparam int CTRL_W   = NUM_CLS + 1 + NUM_PAT + 2;
  localparam int STAT_W   = 4;
  // control word layout
  localparam int C_UCAST  = 0;
  localparam int C_BCAST  = 1;
  localparam int C_MCAST  = 2;
  localparam int C_UHASH  = 3;
  localparam int C_MHASH  = 4;
  localparam int C_PERF   = 5;
  localparam int C_AND    = NUM_CLS;
  localparam int C_PAT0   = NUM_CLS + 1;
  localparam int C_MAGWK  = C_PAT0 + NUM_PAT;
  localparam int C_FILTWK = C_MAGWK + 1;
  // status word layout
  localparam int S_PERF   = 0;
  localparam int S_PAT    = 1;
  localparam int S_FILT   = 2;
  localparam int S_MAGIC  = 3;

  typedef struct packed {
    logic ucast;
    logic bcast;
    logic mcast;
    logic perfect;
  } addr_class_t;
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] dest_i,
  input  logic [AW-1:0] station_i,
  output addr_class_t   cls_o
);
  localparam int GRP_BIT = AW - 8;

  logic all_ones;
  assign all_ones = &dest_i;

  always_comb begin
    cls_o.bcast   = all_ones;
    cls_o.mcast   = dest_i[GRP_BIT] & ~all_ones;
    cls_o.ucast   = ~dest_i[GRP_BIT];
    cls_o.perfect = (dest_i == station_i);
  end

  always_comb begin
    assert (!(cls_o.ucast && (cls_o.mcast || cls_o.bcast))) else $error("AST_ONE_KIND"); // R1
  end
endmodule

// File: rtl/rxf_accept.sv
module rxf_accept
  import rxf_pkg::*;
#(
  parameter int NP = NUM_PAT
) (
  input  addr_class_t     cls_i,
  input  logic            uc_hash_i,
  input  logic            mc_hash_i,
  input  logic [NP-1:0]   pat_hit_i,
  input  logic [NP-1:0]   pat_en_i,
  input  logic [NUM_CLS-1:0] cls_en_i,
  input  logic            and_mode_i,
  output logic            accept_o,
  output logic            pat_o,
  output logic            perf_en_hit_o,
  output logic            hash_en_hit_o
);
  logic [NUM_CLS-1:0] cls_hit;
  logic [NP-1:0]      pat_gated;

  always_comb begin
    cls_hit[C_UCAST] = cls_i.ucast;
    cls_hit[C_BCAST] = cls_i.bcast;
    cls_hit[C_MCAST] = cls_i.mcast;
    cls_hit[C_UHASH] = cls_i.ucast & uc_hash_i;
    cls_hit[C_MHASH] = cls_i.mcast & mc_hash_i;
    cls_hit[C_PERF]  = cls_i.perfect;
  end

  for (genvar k = 0; k < NP; k++) begin : g_pat
    assign pat_gated[k] = pat_hit_i[k] & pat_en_i[k];
  end

  logic grp;
  assign grp           = |(cls_hit & cls_en_i);
  assign pat_o         = |pat_gated;
  assign perf_en_hit_o = cls_hit[C_PERF] & cls_en_i[C_PERF];
  assign hash_en_hit_o = (cls_hit[C_UHASH] & cls_en_i[C_UHASH]) |
                         (cls_hit[C_MHASH] & cls_en_i[C_MHASH]);
  assign accept_o      = and_mode_i ? (grp & pat_o) : (grp | pat_o);

  always_comb begin
    assert (!(pat_en_i == '0 && pat_o)) else $error("AST_PAT_NEEDS_EN"); // R3
  end
endmodule

// File: rtl/rxf_wake_status.sv
module rxf_wake_status
  import rxf_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [SW-1:0] clr_mask_i,
  output logic [SW-1:0] status_o
);
  logic [SW-1:0] status_q;
  logic [SW-1:0] keep;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    assign keep[b] = status_q[b] & ~(clr_we_i & clr_mask_i[b]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= keep[b] | set_i[b];
    end
  end

  assign status_o = status_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R9
endmodule

// File: rtl/rx_addr_filter_wol.sv
module rx_addr_filter_wol
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              uc_hash_hit_i,
  input  logic              mc_hash_hit_i,
  input  logic [NUM_PAT-1:0] pat_hit_i,
  input  logic              magic_hit_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic              decision_valid_o,
  output logic              decision_accept_o,
  output logic [STAT_W-1:0] wake_status_o,
  output logic              wake_irq_o
);
  addr_class_t cls;
  logic accept_c, pat_c, perf_c, hash_c;
  logic [STAT_W-1:0] wake_set;

  rxf_classify #(.AW(ADDR_W)) u_cls (
    .dest_i(dest_addr_i), .station_i(station_addr_i), .cls_o(cls)
  );

  rxf_accept #(.NP(NUM_PAT)) u_acc (
    .cls_i(cls), .uc_hash_i(uc_hash_hit_i), .mc_hash_i(mc_hash_hit_i),
    .pat_hit_i(pat_hit_i), .pat_en_i(ctrl_i[C_PAT0 +: NUM_PAT]),
    .cls_en_i(ctrl_i[NUM_CLS-1:0]), .and_mode_i(ctrl_i[C_AND]),
    .accept_o(accept_c), .pat_o(pat_c), .perf_en_hit_o(perf_c),
    .hash_en_hit_o(hash_c)
  );

  logic filt_ev;
  assign filt_ev = frame_end_i & ctrl_i[C_FILTWK];

  always_comb begin
    wake_set          = '0;
    wake_set[S_PERF]  = filt_ev & perf_c;
    wake_set[S_PAT]   = filt_ev & pat_c;
    wake_set[S_FILT]  = filt_ev & (perf_c | hash_c | pat_c);
    wake_set[S_MAGIC] = frame_end_i & ctrl_i[C_MAGWK] & magic_hit_i;
  end

  rxf_wake_status #(.SW(STAT_W)) u_wst (
    .clk(clk), .rst_n(rst_n), .set_i(wake_set), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .status_o(wake_status_o)
  );

  assign wake_irq_o = |wake_status_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_valid_o  <= 1'b0;
      decision_accept_o <= 1'b0;
    end else begin
      decision_valid_o  <= frame_end_i;
      decision_accept_o <= frame_end_i & accept_c;
    end
  end

  AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> decision_valid_o); // R5
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> (!decision_valid_o && !decision_accept_o)); // R5
  AST_AND_NEEDS_PAT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && ctrl_i[C_AND] && ((pat_hit_i & ctrl_i[C_PAT0 +: NUM_PAT]) == '0))
    |=> !decision_accept_o); // R4
  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !ctrl_i[C_AND] && ctrl_i[C_BCAST] && (&dest_addr_i))
    |=> decision_accept_o); // R2
  AST_MAGIC_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && ctrl_i[C_MAGWK] && magic_hit_i) |=> wake_irq_o); // R7
endmodule

// File: tb/rx_addr_filter_wol_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_wol_tb;
  logic clk = 0, rst_n = 0;
  logic fe = 0, uch = 0, mch = 0, magic = 0, clr_we = 0;
  logic [47:0] dest = '0, sta = 48'h021122334455;
  logic [3:0] pat = 0, clr_mask = 0;
  logic [12:0] ctrl = 0;
  logic dv, da, irq;
  logic [3:0] st;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter_wol u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end_i(fe), .dest_addr_i(dest),
    .station_addr_i(sta), .uc_hash_hit_i(uch), .mc_hash_hit_i(mch),
    .pat_hit_i(pat), .magic_hit_i(magic), .ctrl_i(ctrl), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .decision_valid_o(dv), .decision_accept_o(da),
    .wake_status_o(st), .wake_irq_o(irq)
  );

  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC = 48'h01005E000001;
  localparam logic [47:0] UC = 48'h02AABBCCDDEE;

  function automatic bit m_accept(logic [47:0] d, logic [47:0] s, bit uh,
                                  bit mh, logic [3:0] p, logic [12:0] c);
    bit b = (d == BC);
    bit m = d[40] && !b;
    bit u = !d[40];
    bit g = 0, pm = 0;
    if (c[0] && u) g = 1;
    if (c[1] && b) g = 1;
    if (c[2] && m) g = 1;
    if (c[3] && u && uh) g = 1;
    if (c[4] && m && mh) g = 1;
    if (c[5] && d == s) g = 1;
    for (int i = 0; i < 4; i++) if (c[7+i] && p[i]) pm = 1;
    return c[6] ? (g && pm) : (g || pm);
  endfunction

  function automatic logic [3:0] m_set(logic [47:0] d, logic [47:0] s, bit uh,
                                       bit mh, logic [3:0] p, bit mg, logic [12:0] c);
    logic [3:0] r = 0;
    bit perf = c[5] && d == s;
    bit hash = (c[3] && !d[40] && uh) || (c[4] && d[40] && d != BC && mh);
    bit pm = 0;
    for (int i = 0; i < 4; i++) if (c[7+i] && p[i]) pm = 1;
    if (c[12]) begin
      if (perf) r[0] = 1;
      if (pm) r[1] = 1;
      if (perf || hash || pm) r[2] = 1;
    end
    if (c[11] && mg) r[3] = 1;
    return r;
  endfunction

  logic m_dv = 0, m_da = 0;
  logic [3:0] m_st = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dv <= 0; m_da <= 0; m_st <= 0;
    end else begin
      m_dv <= fe;
      m_da <= fe && m_accept(dest, sta, uch, mch, pat, ctrl);
      m_st <= (clr_we ? (m_st & ~clr_mask) : m_st) |
              (fe ? m_set(dest, sta, uch, mch, pat, magic, ctrl) : 4'h0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 model valid", dv, m_dv);
    chk("R5 model accept", da, m_da);
    chk("R8 model status", st, m_st);
    chk("R10 model irq", irq, (m_st != 0));
  end

  task automatic frame(logic [47:0] d, bit uh, bit mh, logic [3:0] p, bit mg);
    @(negedge clk);
    dest = d; uch = uh; mch = mh; pat = p; magic = mg; fe = 1;
    @(negedge clk);
    fe = 0; uch = 0; mch = 0; pat = 0; magic = 0;
  endtask

  task automatic clear(logic [3:0] m);
    @(negedge clk); clr_we = 1; clr_mask = m;
    @(negedge clk); clr_we = 0; clr_mask = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset valid", dv, 0); chk("R11 reset accept", da, 0);
    chk("R11 reset status", st, 0); chk("R11 reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 after release status", st, 0);
    // classes
    ctrl = 13'h001; frame(UC, 0, 0, 0, 0); chk("R2 all unicast", da, 1);
    chk("R5 pulse", dv, 1);
    @(negedge clk); chk("R5 pulse one cycle", dv, 0);
    frame(MC, 0, 0, 0, 0); chk("R1 multicast not unicast", da, 0);
    ctrl = 13'h004; frame(BC, 0, 0, 0, 0); chk("R1 broadcast not multicast", da, 0);
    frame(MC, 0, 0, 0, 0); chk("R2 all multicast", da, 1);
    ctrl = 13'h002; frame(BC, 0, 0, 0, 0); chk("R2 broadcast", da, 1);
    ctrl = 13'h008; frame(UC, 1, 0, 0, 0); chk("R2 uc hash hit", da, 1);
    frame(UC, 0, 0, 0, 0); chk("R2 uc hash miss", da, 0);
    frame(MC, 1, 0, 0, 0); chk("R2 uc hash on mc frame", da, 0);
    ctrl = 13'h010; frame(MC, 0, 1, 0, 0); chk("R2 mc hash hit", da, 1);
    frame(BC, 0, 1, 0, 0); chk("R1 bc not mc for hash", da, 0);
    ctrl = 13'h020; frame(sta, 0, 0, 0, 0); chk("R2 perfect match", da, 1);
    frame(UC, 0, 0, 0, 0); chk("R2 perfect miss", da, 0);
    // pattern
    ctrl = 13'h200; frame(UC, 0, 0, 4'b0100, 0); chk("R3 unit2 hit", da, 1);
    frame(UC, 0, 0, 4'b0001, 0); chk("R3 unit0 disabled", da, 0);
    // AND/OR
    ctrl = 13'h0C1; frame(UC, 0, 0, 4'b0001, 0); chk("R4 and both", da, 1);
    frame(UC, 0, 0, 0, 0); chk("R4 and no pattern", da, 0);
    frame(MC, 0, 0, 4'b0001, 0); chk("R4 and no class", da, 0);
    ctrl = 13'h041; frame(UC, 0, 0, 4'b1111, 0); chk("R3 none enabled and", da, 0);
    ctrl = 13'h081; frame(MC, 0, 0, 4'b0001, 0); chk("R4 or pattern only", da, 1);
    // wake
    ctrl = 13'h020; frame(sta, 0, 0, 0, 0); chk("R6 no wake when disabled", st, 0);
    ctrl = 13'h1020; frame(sta, 0, 0, 0, 0); chk("R6 perfect wake", st, 4'h5);
    chk("R10 irq set", irq, 1);
    clear(4'h1); chk("R8 partial clear", st, 4'h4); chk("R10 irq held", irq, 1);
    clear(4'h4); chk("R8 full clear", st, 0); chk("R10 irq drops", irq, 0);
    ctrl = 13'h1100; frame(UC, 0, 0, 4'b0010, 0); chk("R6 pattern wake", st, 4'h6);
    clear(4'hF);
    ctrl = 13'h1008; frame(UC, 1, 0, 0, 0); chk("R6 hash wake", st, 4'h4);
    clear(4'hF);
    ctrl = 13'h0000; frame(UC, 0, 0, 0, 1); chk("R7 magic disabled", st, 0);
    ctrl = 13'h0800; frame(UC, 0, 0, 0, 1); chk("R7 magic wake", st, 4'h8);
    repeat (3) @(negedge clk); chk("R8 sticky", st, 4'h8);
    // set beats clear
    @(negedge clk);
    dest = UC; magic = 1; fe = 1; clr_we = 1; clr_mask = 4'hF;
    @(negedge clk);
    fe = 0; magic = 0; clr_we = 0; clr_mask = 0;
    chk("R9 set wins", st, 4'h8);
    clear(4'h8); chk("R8 cleared", st, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule